// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented virtual address into a physical address. A request carries a segment number and an offset. The segment number selects one entry of a small on-chip table. Each entry holds a base, a limit and a present flag. If the entry is present and the offset is strictly below its limit, the block issues the physical address, which is the base plus the offset. If the offset is out of range, it raises a protection fault. If the entry is absent, it raises a segment fault. A faulting request never produces an address.

Software fills the table through a single-cycle write port. One write sets the base, the limit and the present flag of the segment it names. Each lookup takes one clock cycle: a request presented before a rising edge has its result on the outputs after that edge.

Top module: `segxl_translator`

## Requirements
- R1: After a synchronous active-low reset, `xl_valid`, `xl_prot_fault` and `xl_seg_fault` are 0 and `xl_paddr` is 0. Every table entry is absent, with base 0 and limit 0.
- R2: A request sampled with `req_valid` high at a rising edge has its result on the outputs right after that same edge. If `req_valid` is low at an edge, all three flags are 0 and `xl_paddr` is 0 after it.
- R3: `req_seg` indexes the table directly. Each segment keeps its own base and limit, and writing one segment leaves every other segment unchanged.
- R4: If the entry is present and `req_off` is strictly less than its 17-bit limit, `xl_valid` is 1 and `xl_paddr` equals base + offset.
- R5: If the entry is present and `req_off` is greater than or equal to its limit, `xl_prot_fault` is 1, `xl_valid` is 0 and `xl_paddr` is 0. A limit of 0 faults on every offset, and a limit of 0x10000 accepts every offset.
- R6: If the entry is absent, `xl_seg_fault` is 1 and both `xl_valid` and `xl_prot_fault` are 0, whatever the offset and limit.
- R7: After any edge, at most one of `xl_valid`, `xl_prot_fault` and `xl_seg_fault` is 1.
- R8: If a table write and a lookup name the same segment at the same edge, the lookup uses the entry as it was before the write.
- R9: A write with `cfg_we` high at an edge replaces base, limit and present flag of `cfg_seg`, and lookups from the next edge on use the new values. Writing the present flag as 0 removes the segment.
- R10: The sum base + offset is truncated to the 24-bit physical width, so it wraps past 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_seg | input | 3 | Segment written |
| cfg_base | input | 24 | New base value |
| cfg_limit | input | 17 | New limit value (offsets strictly below it are legal) |
| cfg_present | input | 1 | New present flag |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 3 | Segment number of the virtual address |
| req_off | input | 16 | Offset of the virtual address |
| xl_valid | output | 1 | Translation succeeded; `xl_paddr` is meaningful |
| xl_paddr | output | 24 | Physical address, 0 when no translation is issued |
| xl_prot_fault | output | 1 | Offset outside the segment limit |
| xl_seg_fault | output | 1 | Segment not present |

## Verification
The bench uses the default parameters: eight segments, 16-bit offsets, 24-bit bases and a 17-bit limit. With a 17-bit limit, both edge cases can be set up: a limit of zero and a limit that covers the whole 64 KiB offset space. With a 24-bit base, a base near the top of the physical space makes the sum wrap. Three segment-number bits are enough to show that each entry is independent, and to drive a write and a lookup to the same entry at the same edge.

// File: rtl/segxl_pkg.sv
// segxl_pkg
// Shared types of the segment translator.
// Assumes: nothing beyond standard SystemVerilog.
package segxl_pkg;

    // Outcome of one lookup, decided before the output register.
    typedef enum logic [1:0] {
        XR_IDLE = 2'd0,
        XR_HIT  = 2'd1,
        XR_PROT = 2'd2,
        XR_SEG  = 2'd3
    } xl_result_e;

endpackage

// File: rtl/segxl_table.sv
// segxl_table
// Holds one base/limit/present triple per segment. Writes are synchronous.
// The read port is combinational from the stored registers, so a lookup
// made in the same cycle as a write to the same entry sees the old value.
// Assumes: SEG_W bits can name every one of NSEG entries.
module segxl_table #(
    parameter int NSEG   = 8,
    parameter int SEG_W  = 3,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_sel,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_present,
    input  logic [SEG_W-1:0]  rd_sel,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_present
);

    logic [BASE_W-1:0] base_q [NSEG];
    logic [LIM_W-1:0]  lim_q  [NSEG];
    logic              pres_q [NSEG];

    // One register set per entry, loaded when the write names it.
    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        logic hit_w;
        assign hit_w = wr_en && (wr_sel == SEG_W'(g));

        // Entry g: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                lim_q[g]  <= '0;
                pres_q[g] <= 1'b0;
            end else if (hit_w) begin
                base_q[g] <= wr_base;
                lim_q[g]  <= wr_limit;
                pres_q[g] <= wr_present;
            end
        end
    end

    // Read mux: select the entry named by the lookup.
    always_comb begin
        rd_base    = base_q[rd_sel];
        rd_limit   = lim_q[rd_sel];
        rd_present = pres_q[rd_sel];
    end

    // R9: a write lands in the named entry by the next edge.
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base_q[$past(wr_sel)] == $past(wr_base))
               && (lim_q[$past(wr_sel)]  == $past(wr_limit))
               && (pres_q[$past(wr_sel)] == $past(wr_present)));

endmodule

// File: rtl/segxl_check.sv
// segxl_check
// Compares the offset with the selected limit, forms base + offset and
// registers the outcome. The absent check wins over the limit check. No
// address leaves the block unless the request passes both checks.
// Assumes: BASE_W >= OFF_W and LIM_W > OFF_W.
module segxl_check
    import segxl_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int BASE_W = 24,
    parameter int LIM_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_present,
    output logic              out_valid,
    output logic [BASE_W-1:0] out_paddr,
    output logic              out_prot,
    output logic              out_seg
);

    localparam int BPAD = BASE_W - OFF_W;
    localparam int LPAD = LIM_W - OFF_W;

    logic              in_range;
    logic [BASE_W-1:0] sum_w;
    xl_result_e        res_d;

    // Limit compare and address add; the add truncates to BASE_W bits.
    always_comb begin
        in_range = ({{LPAD{1'b0}}, req_off} < ent_limit);
        sum_w    = ent_base + {{BPAD{1'b0}}, req_off};
    end

    // Outcome select: idle, then absent, then out-of-range, else hit.
    always_comb begin
        if (!req_valid)        res_d = XR_IDLE;
        else if (!ent_present) res_d = XR_SEG;
        else if (!in_range)    res_d = XR_PROT;
        else                   res_d = XR_HIT;
    end

    // Output register: one-cycle latency, address only on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prot  <= 1'b0;
            out_seg   <= 1'b0;
            out_paddr <= '0;
        end else begin
            out_valid <= (res_d == XR_HIT);
            out_prot  <= (res_d == XR_PROT);
            out_seg   <= (res_d == XR_SEG);
            out_paddr <= (res_d == XR_HIT) ? sum_w : '0;
        end
    end

    // R7: the three result flags never overlap.
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_prot, out_seg}));

    // R2: a cycle without a request leaves all flags low.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(out_valid || out_prot || out_seg));

    // R6: a request to an absent entry yields only the segment fault.
    p_absent_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ent_present) |=> (out_seg && !out_valid && !out_prot));

    // R5: no address is issued unless the translation is valid.
    p_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_paddr == '0));

endmodule

// File: rtl/segxl_translator.sv
// segxl_translator
// Top level: the segment table plus the limit check and address adder.
// The lookup index goes straight from req_seg to the table read port.
// Assumes: NSEG is a power of two, so every req_seg value names an entry.
module segxl_translator #(
    parameter int NSEG   = 8,
    parameter int OFF_W  = 16,
    parameter int BASE_W = 24,
    parameter int SEG_W  = $clog2(NSEG),
    parameter int LIM_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              cfg_present,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    output logic              xl_valid,
    output logic [BASE_W-1:0] xl_paddr,
    output logic              xl_prot_fault,
    output logic              xl_seg_fault
);

    logic [BASE_W-1:0] sel_base;
    logic [LIM_W-1:0]  sel_limit;
    logic              sel_present;

    segxl_table #(
        .NSEG   (NSEG),
        .SEG_W  (SEG_W),
        .BASE_W (BASE_W),
        .LIM_W  (LIM_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_sel     (cfg_seg),
        .wr_base    (cfg_base),
        .wr_limit   (cfg_limit),
        .wr_present (cfg_present),
        .rd_sel     (req_seg),
        .rd_base    (sel_base),
        .rd_limit   (sel_limit),
        .rd_present (sel_present)
    );

    segxl_check #(
        .OFF_W  (OFF_W),
        .BASE_W (BASE_W),
        .LIM_W  (LIM_W)
    ) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_off     (req_off),
        .ent_base    (sel_base),
        .ent_limit   (sel_limit),
        .ent_present (sel_present),
        .out_valid   (xl_valid),
        .out_paddr   (xl_paddr),
        .out_prot    (xl_prot_fault),
        .out_seg     (xl_seg_fault)
    );

endmodule

// File: tb/tb_segxl_translator.sv
`timescale 1ns/1ps
module tb_segxl_translator;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_seg;
    logic [23:0] cfg_base;
    logic [16:0] cfg_limit;
    logic        cfg_present;
    logic        req_valid;
    logic [2:0]  req_seg;
    logic [15:0] req_off;
    logic        xl_valid;
    logic [23:0] xl_paddr;
    logic        xl_prot_fault;
    logic        xl_seg_fault;

    int n_vec = 0;
    int n_bad = 0;

    // Bench-side copy of the table, kept from the requirements.
    logic [23:0] m_base [8];
    logic [16:0] m_lim  [8];
    logic        m_pres [8];

    always #4 clk = ~clk;

    segxl_translator dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_present(cfg_present),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .xl_valid(xl_valid), .xl_paddr(xl_paddr),
        .xl_prot_fault(xl_prot_fault), .xl_seg_fault(xl_seg_fault)
    );

    task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual={v,pf,sf,pa}=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected outcome computed from R4/R5/R6/R10.
    function automatic logic [26:0] expect_of(input logic [2:0] s, input logic [15:0] o);
        if (!m_pres[s])                 return {3'b001, 24'h0};
        if ({1'b0, o} >= m_lim[s])      return {3'b010, 24'h0};
        return {3'b100, m_base[s] + {8'h0, o}};
    endfunction

    task automatic write_seg(input logic [2:0] s, input logic [23:0] b,
                             input logic [16:0] l, input logic p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_limit = l; cfg_present = p;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[s] = b; m_lim[s] = l; m_pres[s] = p;
    endtask

    task automatic lookup(input logic [2:0] s, input logic [15:0] o, input string tag);
        logic [26:0] act;
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        act = {xl_valid, xl_prot_fault, xl_seg_fault, xl_paddr};
        check(tag, act, expect_of(s, o));
        n_vec++;
        if ($countones({xl_valid, xl_prot_fault, xl_seg_fault}) > 1) begin
            n_bad++;
            $display("FAIL R7 flags overlap actual=%b expected=at most one",
                     {xl_valid, xl_prot_fault, xl_seg_fault});
        end
    endtask

    // R1: reset state at the ports, and every entry absent.
    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", {xl_valid, xl_prot_fault, xl_seg_fault, xl_paddr}, 27'h0);
        for (int i = 0; i < 8; i++) lookup(3'(i), 16'h0000, "R1 entry absent after reset");
    endtask

    // R2: a cycle without a request clears the outputs.
    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; req_seg = 3'd1; req_off = 16'h0010;
        @(posedge clk);
        @(negedge clk);
        check("R2 idle outputs", {xl_valid, xl_prot_fault, xl_seg_fault, xl_paddr}, 27'h0);
    endtask

    // R4/R5/R9: basic hit and limit boundary.
    task automatic t_basic();
        write_seg(3'd1, 24'h100000, 17'h01000, 1'b1);
        lookup(3'd1, 16'h0000, "R4 hit at offset 0");
        lookup(3'd1, 16'h0FFF, "R4 hit at limit-1");
        lookup(3'd1, 16'h1000, "R5 fault at limit");
        lookup(3'd1, 16'hFFFF, "R5 fault far beyond limit");
        t_idle();
    endtask

    // R3: entries are independent.
    task automatic t_indep();
        write_seg(3'd3, 24'h4A0000, 17'h00200, 1'b1);
        lookup(3'd3, 16'h01FF, "R3 seg3 own base");
        lookup(3'd1, 16'h01FF, "R3 seg1 unchanged");
        lookup(3'd3, 16'h0800, "R3 seg3 own limit");
        lookup(3'd2, 16'h0000, "R3 seg2 still absent");
    endtask

    // R5: zero and full limits.
    task automatic t_limits();
        write_seg(3'd4, 24'h200000, 17'h00000, 1'b1);
        lookup(3'd4, 16'h0000, "R5 zero limit faults");
        write_seg(3'd5, 24'h300000, 17'h10000, 1'b1);
        lookup(3'd5, 16'hFFFF, "R5 full limit accepts max offset");
    endtask

    // R10: the sum wraps at the physical width.
    task automatic t_wrap();
        write_seg(3'd6, 24'hFFFF00, 17'h10000, 1'b1);
        lookup(3'd6, 16'h0200, "R10 wrapped address");
    endtask

    // R6/R9: removing a segment gives a segment fault.
    task automatic t_absent();
        write_seg(3'd1, 24'h100000, 17'h10000, 1'b0);
        lookup(3'd1, 16'h0004, "R6 absent segment in range");
        lookup(3'd7, 16'hFFFF, "R6 never-written segment");
    endtask

    // R8: write and lookup to the same segment at the same edge.
    task automatic t_collide();
        logic [26:0] old_exp;
        write_seg(3'd2, 24'h0A0000, 17'h00100, 1'b1);
        old_exp = expect_of(3'd2, 16'h0080);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = 3'd2; cfg_base = 24'h0B0000;
        cfg_limit = 17'h00040; cfg_present = 1'b1;
        req_valid = 1'b1; req_seg = 3'd2; req_off = 16'h0080;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_base[2] = 24'h0B0000; m_lim[2] = 17'h00040; m_pres[2] = 1'b1;
        check("R8 same-edge lookup sees old entry",
              {xl_valid, xl_prot_fault, xl_seg_fault, xl_paddr}, old_exp);
        lookup(3'd2, 16'h0080, "R9 new limit applies next cycle");
        lookup(3'd2, 16'h0010, "R9 new base applies next cycle");
    endtask

    initial begin
        cfg_we = 1'b0; cfg_seg = '0; cfg_base = '0; cfg_limit = '0; cfg_present = 1'b0;
        req_valid = 1'b0; req_seg = '0; req_off = '0; rst_n = 1'b0;
        t_reset();
        t_idle();
        t_basic();
        t_indep();
        t_limits();
        t_wrap();
        t_absent();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog R2 actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule